// File: doc/BRIEF.md
# AUX Channel Request Buffer and Transaction Engine

This block sits between a CPU register port and the byte-level link of a DisplayPort AUX master. Software builds a request in a shared 144-entry byte buffer through one data register. The request is a four-byte header, followed by the payload when the request is a write. Software then launches it with one control write that chooses native AUX or I2C-over-AUX. The engine first checks the header against the length limits of the chosen mode. It then streams the request bytes out on a valid/ready byte link and waits for the reply. Reply data lands back in the same buffer, and the outcome is posted as status bits that feed one interrupt line.

The header layout is fixed, because the engine decodes it:
- Byte 0 holds the address nibble in bits 3:0, the read marker in bit 4, and bits 7:5, which must be zero.
- Bytes 1 and 2 hold the remaining address bits, high byte first.
- Byte 3 holds the transfer length minus one.

Register word addresses are 0 data, 1 transfer control, 2 link control, 3 status and 4 interrupt mask.

Top module: `auxreq_top`

## Requirements
- R1: A data-register write (address 0) with bit 9 set and bit 8 clear stores bits 7:0 at entry 0. Each later write without bit 9 stores at the next entry. Writes past entry 143 are dropped and never wrap onto entry 0.
- R2: A data write with bits 9 and 8 both set moves the pointer to entry 0 and stores nothing. Each data read returns the staged byte in bits 15:8 and stages the byte at the pointer, then advances the pointer. The first read therefore returns the previously staged byte, which is 0 after reset, and the second read returns entry 0. Reads past the last entry return 0.
- R3: Writing 1 to transfer-control bit 0 (GO) starts a transaction only when link-control bit 1 (enable) is set and bit 0 (hold) is clear. The engine sends entries 0..N-1 on the byte link, where N is 4 for a read (header byte 0 bit 4 set) and 4 plus the length for a write. The length is header byte 3 plus one. txLast marks byte N-1, and txData stays stable while txValid waits for txReady.
- R4: txI2c equals transfer-control bit 1, which is captured by the GO write.
- R5: For a read, reply bytes on rxValid are stored from entry 0 up to the requested length. A reply ending with rxDone and code 0 (ACK) sets status bit 0 (done).
- R6: A length above 16 in native mode or above 128 in I2C mode, or a write whose header plus payload exceeds 144 bytes, sets status bit 4 (count error) and sends nothing.
- R7: A header byte 0 with any of bits 7:5 set sets status bit 1 (address error) and sends nothing.
- R8: Reply code 1 (NACK) or 2 (DEFER) sets status bit 3 in native mode. In I2C mode, NACK sets bit 5 and DEFER sets bit 6. Code 3 is treated as NACK.
- R9: An ACK reply to a read that carries fewer bytes than requested sets status bit 4 instead of done.
- R10: If no rxDone arrives within TIMEOUT_CYCLES cycles after the last request byte, status bit 2 is set and the engine returns to idle.
- R11: Writing the transfer-control register with bit 0 clear while busy aborts the transaction without setting any status bit. A GO written while busy is ignored. Transfer-control bit 0 reads back as busy.
- R12: Data-register accesses are ignored while busy or while hold is set. Hold also returns the pointer to entry 0 and the engine to idle.
- R13: Status bits clear when written with 1. irq is the OR of the status bits that are set in the mask register. All status bits are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWe | input | 1 | Register write strobe |
| cpuRe | input | 1 | Register read strobe (side effect on the data register) |
| cpuAddr | input | 3 | Register word address |
| cpuWdata | input | 32 | Register write data |
| cpuRdata | output | 32 | Register read data, combinational from cpuAddr |
| irq | output | 1 | OR of the masked status bits |
| txValid | output | 1 | Request byte valid |
| txReady | input | 1 | Link accepts the request byte |
| txData | output | 8 | Request byte |
| txLast | output | 1 | Final request byte |
| txI2c | output | 1 | Transaction uses I2C-over-AUX |
| rxValid | input | 1 | Reply byte valid |
| rxData | input | 8 | Reply byte |
| rxDone | input | 1 | Reply complete, with rxCode |
| rxCode | input | 2 | Reply code: 0 ACK, 1 NACK, 2 DEFER |

## Verification
The bench keeps the default buffer depth of 144 and the default mode limits of 16 and 128. This lets it probe a 17-byte native write, a 129-byte I2C read and a full 128-byte I2C write that fills 132 entries. It also overfills the buffer to show that entries do not wrap. TIMEOUT_CYCLES is lowered to 40, so the wait-for-reply timeout can be observed both before and after it expires within a short run.

// File: rtl/auxreq_pkg.sv
package auxreq_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned STAT_W = 7;

  localparam int unsigned ST_DONE    = 0;
  localparam int unsigned ST_BADADDR = 1;
  localparam int unsigned ST_TMO     = 2;
  localparam int unsigned ST_NREFUSE = 3;
  localparam int unsigned ST_CNT     = 4;
  localparam int unsigned ST_INACK   = 5;
  localparam int unsigned ST_IDEFER  = 6;

  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_XFER = 3'd1;
  localparam logic [2:0] A_LINK = 3'd2;
  localparam logic [2:0] A_STAT = 3'd3;
  localparam logic [2:0] A_MASK = 3'd4;

  localparam int unsigned DF_READ   = 8;
  localparam int unsigned DF_REWIND = 9;

  localparam logic [1:0] RC_ACK   = 2'd0;
  localparam logic [1:0] RC_NACK  = 2'd1;
  localparam logic [1:0] RC_DEFER = 2'd2;

  typedef struct packed {
    logic              ptrClr;
    logic              ptrInc;
    logic              capWr;
    logic [STAT_W-1:0] statSet;
  } engStrobe_t;

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_SEND, S_WAIT} engState_t;
endpackage

// File: rtl/auxreq_datapath.sv
module auxreq_datapath
  import auxreq_pkg::*;
#(
  parameter int unsigned DEPTH = 144,
  parameter int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWe,
  input  logic             cpuRe,
  input  logic [2:0]       cpuAddr,
  input  logic [REG_W-1:0] cpuWdata,
  output logic [REG_W-1:0] cpuRdata,
  output logic             irq,
  input  logic             engBusy,
  input  engStrobe_t       stb,
  input  logic [7:0]       rxData,
  output logic [PTR_W-1:0] ptr,
  output logic [7:0]       curByte,
  output logic [7:0]       hdr0,
  output logic [7:0]       hdr3,
  output logic             goPulse,
  output logic             abortPulse,
  output logic             i2cSel,
  output logic             engOn,
  output logic             holdRst
);
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(DEPTH);

  logic [7:0]        mem [DEPTH];
  logic [PTR_W-1:0]  ptrQ;
  logic [7:0]        stage;
  logic              i2cQ, holdQ, enQ;
  logic [STAT_W-1:0] statQ, maskQ;

  logic dataWr, dataRd, rewind, rdFlag, xferWr, cpuStore, inRange;
  logic [IDX_W-1:0] ptrIdx, storeIdx;
  logic [PTR_W-1:0] ptrStep;
  logic [STAT_W-1:0] clrBits;
  logic unusedBits;

  assign unusedBits = ^cpuWdata[REG_W-1:DF_REWIND+1];

  assign dataWr  = cpuWe && (cpuAddr == A_DATA) && !engBusy && !holdQ;
  assign dataRd  = cpuRe && (cpuAddr == A_DATA) && !engBusy && !holdQ;
  assign rewind  = cpuWdata[DF_REWIND];
  assign rdFlag  = cpuWdata[DF_READ];
  assign xferWr  = cpuWe && (cpuAddr == A_XFER);
  assign inRange = ptrQ < PTR_END;
  assign ptrIdx  = ptrQ[IDX_W-1:0];
  assign ptrStep = inRange ? ptrQ + PTR_W'(1) : ptrQ;

  assign cpuStore = dataWr && !(rewind && rdFlag) && (rewind || inRange);
  assign storeIdx = rewind ? '0 : ptrIdx;

  always_ff @(posedge clk) begin
    if (cpuStore) begin
      mem[storeIdx] <= cpuWdata[7:0];
    end else if (stb.capWr && inRange) begin
      mem[ptrIdx] <= rxData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (holdQ || stb.ptrClr) begin
      ptrQ <= '0;
    end else if (stb.ptrInc || dataRd) begin
      ptrQ <= ptrStep;
    end else if (dataWr) begin
      if (rewind) ptrQ <= rdFlag ? '0 : PTR_W'(1);
      else        ptrQ <= ptrStep;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage <= '0;
    end else if (holdQ) begin
      stage <= '0;
    end else if (dataRd) begin
      stage <= inRange ? mem[ptrIdx] : 8'h00;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      i2cQ  <= 1'b0;
      holdQ <= 1'b0;
      enQ   <= 1'b0;
      maskQ <= '0;
    end else begin
      if (xferWr && !engBusy) i2cQ <= cpuWdata[1];
      if (cpuWe && cpuAddr == A_LINK) begin
        holdQ <= cpuWdata[0];
        enQ   <= cpuWdata[1];
      end
      if (cpuWe && cpuAddr == A_MASK) maskQ <= cpuWdata[STAT_W-1:0];
    end
  end

  assign clrBits = (cpuWe && cpuAddr == A_STAT) ? cpuWdata[STAT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~clrBits) | stb.statSet;
  end

  always_comb begin
    unique case (cpuAddr)
      A_DATA:  cpuRdata = {16'h0000, stage, 8'h00};
      A_XFER:  cpuRdata = {30'd0, i2cQ, engBusy};
      A_LINK:  cpuRdata = {30'd0, enQ, holdQ};
      A_STAT:  cpuRdata = REG_W'(statQ);
      A_MASK:  cpuRdata = REG_W'(maskQ);
      default: cpuRdata = '0;
    endcase
  end

  assign irq        = |(statQ & maskQ);
  assign ptr        = ptrQ;
  assign curByte    = inRange ? mem[ptrIdx] : 8'h00;
  assign hdr0       = mem[0];
  assign hdr3       = mem[3];
  assign goPulse    = xferWr && cpuWdata[0];
  assign abortPulse = xferWr && !cpuWdata[0];
  assign i2cSel     = i2cQ;
  assign engOn      = enQ && !holdQ;
  assign holdRst    = holdQ;
endmodule

// File: rtl/auxreq_control.sv
module auxreq_control
  import auxreq_pkg::*;
#(
  parameter int unsigned DEPTH          = 144,
  parameter int unsigned NATIVE_MAX     = 16,
  parameter int unsigned I2C_MAX        = 128,
  parameter int unsigned TIMEOUT_CYCLES = 1000,
  parameter int unsigned PTR_W          = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             goPulse,
  input  logic             abortPulse,
  input  logic             engOn,
  input  logic             holdRst,
  input  logic             i2cSel,
  input  logic [7:0]       hdr0,
  input  logic [7:0]       hdr3,
  input  logic [7:0]       curByte,
  input  logic [PTR_W-1:0] ptr,
  input  logic             txReady,
  input  logic             rxValid,
  input  logic             rxDone,
  input  logic [1:0]       rxCode,
  output engStrobe_t       stb,
  output logic             busy,
  output logic             txValid,
  output logic             txLast,
  output logic             txI2c,
  output logic [7:0]       txData
);
  localparam int unsigned LEN_W = (PTR_W > 9) ? PTR_W : 9;
  localparam int unsigned TMO_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [LEN_W-1:0] NAT_LIM  = LEN_W'(NATIVE_MAX);
  localparam logic [LEN_W-1:0] I2C_LIM  = LEN_W'(I2C_MAX);
  localparam logic [LEN_W:0]   DEPTH_L  = (LEN_W + 1)'(DEPTH);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYCLES - 1);

  engState_t        st, stNext;
  logic             isReadQ;
  logic [LEN_W-1:0] lenQ, totalQ;
  logic [TMO_W-1:0] tmoQ;

  logic [LEN_W-1:0] hdrLen, lim, ptrL, gotCnt;
  logic hdrRead, badAddr, badCount, overDepth, lastByte, capNow, tmoHit;
  logic unusedHdr;

  assign unusedHdr = ^hdr0[3:0];
  assign hdrLen    = LEN_W'(hdr3) + LEN_W'(1);
  assign hdrRead   = hdr0[4];
  assign badAddr   = |hdr0[7:5];
  assign lim       = i2cSel ? I2C_LIM : NAT_LIM;
  assign overDepth = !hdrRead && (({1'b0, hdrLen} + (LEN_W + 1)'(4)) > DEPTH_L);
  assign badCount  = (hdrLen > lim) || overDepth;
  assign ptrL      = LEN_W'(ptr);
  assign lastByte  = (ptrL == totalQ - LEN_W'(1));
  assign capNow    = (st == S_WAIT) && rxValid && isReadQ && (ptrL < lenQ);
  assign gotCnt    = ptrL + LEN_W'(capNow);
  assign tmoHit    = (tmoQ == TMO_LAST);

  always_comb begin
    stNext  = st;
    stb     = '0;
    txValid = 1'b0;
    unique case (st)
      S_IDLE: begin
        if (goPulse && engOn) begin
          stNext     = S_CHECK;
          stb.ptrClr = 1'b1;
        end
      end
      S_CHECK: begin
        if (badAddr || badCount) begin
          stNext                 = S_IDLE;
          stb.statSet[ST_BADADDR] = badAddr;
          stb.statSet[ST_CNT]     = badCount;
        end else begin
          stNext = S_SEND;
        end
      end
      S_SEND: begin
        txValid = 1'b1;
        if (txReady) begin
          if (lastByte) begin
            stb.ptrClr = 1'b1;
            stNext     = S_WAIT;
          end else begin
            stb.ptrInc = 1'b1;
          end
        end
      end
      S_WAIT: begin
        if (capNow) begin
          stb.capWr  = 1'b1;
          stb.ptrInc = 1'b1;
        end
        if (rxDone) begin
          stNext = S_IDLE;
          unique case (rxCode)
            RC_ACK: begin
              if (isReadQ && gotCnt < lenQ) stb.statSet[ST_CNT]  = 1'b1;
              else                          stb.statSet[ST_DONE] = 1'b1;
            end
            RC_DEFER: begin
              if (i2cSel) stb.statSet[ST_IDEFER]  = 1'b1;
              else        stb.statSet[ST_NREFUSE] = 1'b1;
            end
            default: begin
              if (i2cSel) stb.statSet[ST_INACK]   = 1'b1;
              else        stb.statSet[ST_NREFUSE] = 1'b1;
            end
          endcase
        end else if (tmoHit) begin
          stNext              = S_IDLE;
          stb.statSet[ST_TMO] = 1'b1;
        end
      end
      default: stNext = S_IDLE;
    endcase
    if ((abortPulse && st != S_IDLE) || holdRst) begin
      stNext  = S_IDLE;
      stb     = '0;
      txValid = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st      <= S_IDLE;
      isReadQ <= 1'b0;
      lenQ    <= '0;
      totalQ  <= '0;
      tmoQ    <= '0;
    end else begin
      st <= stNext;
      if (st == S_CHECK) begin
        isReadQ <= hdrRead;
        lenQ    <= hdrLen;
        totalQ  <= hdrRead ? LEN_W'(4) : hdrLen + LEN_W'(4);
      end
      if (st == S_WAIT) tmoQ <= tmoQ + TMO_W'(1);
      else              tmoQ <= '0;
    end
  end

  assign busy   = (st != S_IDLE);
  assign txData = curByte;
  assign txLast = txValid && lastByte;
  assign txI2c  = i2cSel;
endmodule

// File: rtl/auxreq_top.sv
module auxreq_top
  import auxreq_pkg::*;
#(
  parameter int unsigned DEPTH          = 144,
  parameter int unsigned NATIVE_MAX     = 16,
  parameter int unsigned I2C_MAX        = 128,
  parameter int unsigned TIMEOUT_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuWe,
  input  logic        cpuRe,
  input  logic [2:0]  cpuAddr,
  input  logic [31:0] cpuWdata,
  output logic [31:0] cpuRdata,
  output logic        irq,
  output logic        txValid,
  input  logic        txReady,
  output logic [7:0]  txData,
  output logic        txLast,
  output logic        txI2c,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  logic        rxDone,
  input  logic [1:0]  rxCode
);
  localparam int unsigned PTR_W = $clog2(DEPTH + 1);

  engStrobe_t       stb;
  logic             engBusy, goPulse, abortPulse, i2cSel, engOn, holdRst;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       curByte, hdr0, hdr3;

  auxreq_datapath #(.DEPTH(DEPTH), .PTR_W(PTR_W)) dp_i (
    .clk(clk), .rstN(rstN),
    .cpuWe(cpuWe), .cpuRe(cpuRe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuRdata(cpuRdata), .irq(irq),
    .engBusy(engBusy), .stb(stb), .rxData(rxData),
    .ptr(ptr), .curByte(curByte), .hdr0(hdr0), .hdr3(hdr3),
    .goPulse(goPulse), .abortPulse(abortPulse), .i2cSel(i2cSel),
    .engOn(engOn), .holdRst(holdRst)
  );

  auxreq_control #(
    .DEPTH(DEPTH), .NATIVE_MAX(NATIVE_MAX), .I2C_MAX(I2C_MAX),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .PTR_W(PTR_W)
  ) ctl_i (
    .clk(clk), .rstN(rstN),
    .goPulse(goPulse), .abortPulse(abortPulse), .engOn(engOn), .holdRst(holdRst),
    .i2cSel(i2cSel), .hdr0(hdr0), .hdr3(hdr3), .curByte(curByte), .ptr(ptr),
    .txReady(txReady), .rxValid(rxValid), .rxDone(rxDone), .rxCode(rxCode),
    .stb(stb), .busy(engBusy), .txValid(txValid), .txLast(txLast),
    .txI2c(txI2c), .txData(txData)
  );
endmodule

// File: rtl/auxreq_checker.sv
module auxreq_checker #(
  parameter int unsigned DEPTH = 144,
  parameter int unsigned PTR_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             txValid,
  input logic             txReady,
  input logic [7:0]       txData,
  input logic             txLast,
  input logic             engBusy,
  input logic             goPulse,
  input logic             engOn,
  input logic             abortPulse,
  input logic             holdRst,
  input logic [PTR_W-1:0] ptr
);
  AST_GO_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (goPulse && !engBusy && !engOn) |=> !engBusy); // R12
  AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (goPulse && !engBusy && engOn) |=> engBusy); // R3
  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    holdRst |=> (!engBusy && ptr == '0)); // R12
  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    (engBusy && abortPulse) |=> !engBusy); // R11
  AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady && !abortPulse && !holdRst) |=> (txValid && $stable(txData))); // R3
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid); // R3
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= PTR_W'(DEPTH)); // R1
endmodule

bind auxreq_top auxreq_checker #(.DEPTH(DEPTH), .PTR_W(PTR_W)) chk_i (.*);

// File: tb/auxreq_top_tb_top.sv
module auxreq_top_tb_top;
  import auxreq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;

  typedef logic [7:0] bq_t[$];

  logic clk = 1'b0, rstN = 1'b0;
  logic cpuWe = 0, cpuRe = 0;
  logic [2:0] cpuAddr = '0;
  logic [31:0] cpuWdata = '0, cpuRdata;
  logic irq, txValid, txReady, txLast, txI2c;
  logic [7:0] txData, rxData = '0;
  logic rxValid = 0, rxDone = 0;
  logic [1:0] rxCode = '0;

  int nChecks = 0, nErr = 0, cyc = 0;
  bit expI2c = 0;
  logic [8:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  auxreq_top #(.TIMEOUT_CYCLES(TMO)) dut_i (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuRe(cpuRe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .irq(irq),
    .txValid(txValid), .txReady(txReady), .txData(txData), .txLast(txLast),
    .txI2c(txI2c), .rxValid(rxValid), .rxData(rxData), .rxDone(rxDone), .rxCode(rxCode)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // link ready pattern
  initial begin
    txReady = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      txReady = (cyc % 4) != 1;
    end
  end

  // monitor: pops the scoreboard on every accepted byte
  initial begin
    logic [8:0] e;
    forever begin
      @(negedge clk);
      #1;
      if (rstN && txValid && txReady) begin
        if (expQ.size() == 0) chk(0, "R3 unexpected tx byte", {23'd0, txLast, txData}, 0);
        else begin
          e = expQ.pop_front();
          chk(txData == e[7:0] && txLast == e[8], "R3 tx byte/last", {23'd0, txLast, txData}, {23'd0, e});
          chk(txI2c == expI2c, "R4 tx mode", {31'd0, txI2c}, {31'd0, expI2c});
        end
      end
    end
  end

  task automatic cpuWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cpuWe = 1; cpuAddr = a; cpuWdata = d;
    @(negedge clk); cpuWe = 0;
  endtask

  task automatic cpuRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cpuRe = 1; cpuAddr = a;
    #1 d = cpuRdata;
    @(negedge clk); cpuRe = 0;
  endtask

  task automatic readByte(output logic [7:0] b);
    logic [31:0] v;
    cpuRead(A_DATA, v);
    b = v[15:8];
  endtask

  task automatic loadBytes(input bq_t q);
    foreach (q[i]) cpuWrite(A_DATA, (i == 0 ? 32'h200 : 32'h0) | 32'(q[i]));
  endtask

  // driver: loads, pushes expected stream, launches
  task automatic goReq(input bq_t q, input bit i2c, input bit sends);
    int n;
    loadBytes(q);
    expI2c = i2c;
    if (sends) begin
      n = q[0][4] ? 4 : q.size();
      for (int i = 0; i < n; i++) expQ.push_back({(i == n - 1), q[i]});
    end
    cpuWrite(A_XFER, i2c ? 32'h3 : 32'h1);
    if (sends) begin
      while (expQ.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
    end else repeat (4) @(negedge clk);
  endtask

  task automatic reply(input bq_t q, input logic [1:0] code);
    foreach (q[i]) begin
      @(negedge clk); rxValid = 1; rxData = q[i];
    end
    @(negedge clk); rxValid = 0; rxDone = 1; rxCode = code;
    @(negedge clk); rxDone = 0;
  endtask

  task automatic statusIs(input logic [6:0] exp, input string req);
    logic [31:0] v;
    cpuRead(A_STAT, v);
    chk(v[6:0] == exp, req, v, {25'd0, exp});
    cpuWrite(A_STAT, 32'h7F);
  endtask

  task automatic busyIs(input bit exp, input string req);
    logic [31:0] v;
    cpuRead(A_XFER, v);
    chk(v[0] == exp, req, v, {31'd0, exp});
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErr++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    logic [7:0] b;
    bq_t q;
    repeat (3) @(negedge clk);
    rstN = 1;

    // reset state
    cpuRead(A_STAT, v); chk(v == 0, "R13 status after reset", v, 0);
    cpuRead(A_XFER, v); chk(v == 0, "R11 xfer after reset", v, 0);
    chk(irq == 0, "R13 irq after reset", {31'd0, irq}, 0);
    cpuWrite(A_LINK, 32'h2);
    cpuWrite(A_MASK, 32'h7F);

    // R1 / R2 store and read back
    loadBytes('{8'h11, 8'h22, 8'h33});
    cpuWrite(A_DATA, 32'h300);
    readByte(b); chk(b == 8'h00, "R2 first read is staged value", b, 0);
    readByte(b); chk(b == 8'h11, "R1 entry0", b, 8'h11);
    readByte(b); chk(b == 8'h22, "R1 entry1", b, 8'h22);
    readByte(b); chk(b == 8'h33, "R2 entry2", b, 8'h33);

    // R3 native write, 3 payload bytes
    goReq('{8'h05, 8'h12, 8'h34, 8'h02, 8'hA1, 8'hA2, 8'hA3}, 0, 1);
    busyIs(1, "R3 busy awaiting reply");
    reply('{}, RC_ACK);
    @(negedge clk);
    chk(irq == 1, "R13 irq on done", {31'd0, irq}, 1);
    statusIs(7'h01, "R5 native write done");
    chk(irq == 0, "R13 irq after W1C", {31'd0, irq}, 0);

    // R5 I2C read of 4 bytes
    goReq('{8'h15, 8'h00, 8'h50, 8'h03}, 1, 1);
    reply('{8'hDE, 8'hAD, 8'hBE, 8'hEF}, RC_ACK);
    statusIs(7'h01, "R5 i2c read done");
    cpuWrite(A_DATA, 32'h300);
    readByte(b);
    readByte(b); chk(b == 8'hDE, "R5 reply byte0", b, 8'hDE);
    readByte(b); chk(b == 8'hAD, "R5 reply byte1", b, 8'hAD);
    readByte(b); chk(b == 8'hBE, "R5 reply byte2", b, 8'hBE);
    readByte(b); chk(b == 8'hEF, "R5 reply byte3", b, 8'hEF);

    // R9 short reply
    goReq('{8'h15, 8'h00, 8'h50, 8'h03}, 1, 1);
    reply('{8'h01, 8'h02}, RC_ACK);
    statusIs(7'h10, "R9 short reply count error");

    // R6 limits
    goReq('{8'h00, 8'h00, 8'h00, 8'h10}, 0, 0);
    statusIs(7'h10, "R6 native length 17 rejected");
    busyIs(0, "R6 idle after reject");
    goReq('{8'h10, 8'h00, 8'h00, 8'h80}, 1, 0);
    statusIs(7'h10, "R6 i2c length 129 rejected");
    q = '{8'h00, 8'h00, 8'h00, 8'h7F};
    for (int i = 0; i < 128; i++) q.push_back(8'(i) ^ 8'hC3);
    goReq(q, 1, 1);
    reply('{}, RC_ACK);
    statusIs(7'h01, "R6 i2c length 128 accepted");

    // R7 bad address
    goReq('{8'h25, 8'h00, 8'h00, 8'h00}, 0, 0);
    statusIs(7'h02, "R7 address error");

    // R8 refusals
    goReq('{8'h10, 8'h00, 8'h01, 8'h00}, 0, 1);
    reply('{}, RC_NACK);
    statusIs(7'h08, "R8 native nack");
    goReq('{8'h10, 8'h00, 8'h01, 8'h00}, 0, 1);
    reply('{}, RC_DEFER);
    statusIs(7'h08, "R8 native defer");
    goReq('{8'h10, 8'h00, 8'h01, 8'h00}, 1, 1);
    reply('{}, RC_NACK);
    statusIs(7'h20, "R8 i2c nack");
    goReq('{8'h10, 8'h00, 8'h01, 8'h00}, 1, 1);
    reply('{}, RC_DEFER);
    statusIs(7'h40, "R8 i2c defer");
    goReq('{8'h10, 8'h00, 8'h01, 8'h00}, 1, 1);
    reply('{}, 2'd3);
    statusIs(7'h20, "R8 code 3 as nack");

    // R10 timeout
    goReq('{8'h10, 8'h00, 8'h01, 8'h00}, 0, 1);
    repeat (20) @(negedge clk);
    busyIs(1, "R10 still waiting before limit");
    repeat (40) @(negedge clk);
    busyIs(0, "R10 idle after timeout");
    statusIs(7'h04, "R10 timeout status");

    // R11 / R12 while busy
    goReq('{8'h10, 8'h00, 8'h50, 8'h00}, 1, 1);
    cpuWrite(A_DATA, 32'h299);
    cpuWrite(A_XFER, 32'h3);
    busyIs(1, "R11 go while busy ignored");
    cpuWrite(A_XFER, 32'h0);
    busyIs(0, "R11 abort clears busy");
    statusIs(7'h00, "R11 abort sets no status");
    cpuWrite(A_DATA, 32'h300);
    readByte(b);
    readByte(b); chk(b == 8'h10, "R12 data write ignored while busy", b, 8'h10);

    // R12 hold and enable gating
    cpuWrite(A_LINK, 32'h3);
    cpuWrite(A_XFER, 32'h1);
    repeat (3) @(negedge clk);
    busyIs(0, "R12 go ignored under hold");
    cpuWrite(A_DATA, 32'h277);
    cpuWrite(A_LINK, 32'h0);
    cpuWrite(A_XFER, 32'h1);
    repeat (3) @(negedge clk);
    busyIs(0, "R12 go ignored when disabled");
    cpuWrite(A_LINK, 32'h2);
    cpuWrite(A_DATA, 32'h300);
    readByte(b);
    readByte(b); chk(b == 8'h10, "R12 data write ignored under hold", b, 8'h10);

    // R13 mask
    goReq('{8'h05, 8'h00, 8'h00, 8'h00, 8'h44}, 0, 1);
    reply('{}, RC_ACK);
    cpuWrite(A_MASK, 32'h7E);
    chk(irq == 0, "R13 masked done", {31'd0, irq}, 0);
    cpuWrite(A_STAT, 32'h7E);
    cpuWrite(A_MASK, 32'h01);
    chk(irq == 1, "R13 W1C zero bits keep status", {31'd0, irq}, 1);
    statusIs(7'h01, "R13 status kept");

    // R1 overfill
    for (int i = 0; i < 146; i++)
      cpuWrite(A_DATA, (i == 0 ? 32'h200 : 32'h0) | 32'(i < 144 ? (8'(i) ^ 8'h5A) : 8'hEE));
    cpuWrite(A_DATA, 32'h300);
    readByte(b);
    for (int i = 0; i < 144; i++) begin
      readByte(b);
      if (i == 0 || i == 143 || b != (8'(i) ^ 8'h5A))
        chk(b == (8'(i) ^ 8'h5A), "R1 overfill entry", b, 32'(8'(i) ^ 8'h5A));
    end
    readByte(b); chk(b == 8'h00, "R2 read past end", b, 0);

    finishRun();
  end
endmodule